// File: doc/BRIEF.md
# I2C Target Front End with SCL Phase Watchdog

This block is the bus-facing half of an I2C target. It oversamples the SCL and SDA lines with the system clock, cleans them with a synchronizer and a short glitch filter, and recognises Start and Stop. It takes in an address byte and compares it against a fixed 7-bit identity: group bits `1010` followed by a 3-bit device code that defaults to `110`. It answers with an acknowledge, then moves write data to a byte stream or shifts read data out from a second byte stream. The block never stretches the clock. Flow control toward the system side is done by acknowledging or refusing bytes.

A phase watchdog runs while a transfer is open, meaning after a Start and before a Stop. It measures how long the filtered SCL stays at one level. If a high or low phase lasts too long, the watchdog emits a one-cycle pulse and the protocol logic drops back to idle. From idle, everything except a fresh Start is ignored.

Received bytes leave on a valid/ready output. A byte is held until accepted. Because the bus cannot be stalled, a byte that completes while the previous one is still waiting is refused on the bus and discarded. Read bytes are taken from a valid/ready input at the moment each byte begins. When no byte is offered, all ones are sent.

Top module: `i2c_tgt_wdt`

## Requirements
- R1: An address byte is acknowledged only when bits 7..1 equal `1010_110` (bit 0 is the direction: 0 = write to the target, 1 = read from the target). Any other address gets no acknowledge, and the bytes that follow it are neither acknowledged nor delivered until the next Start or Stop.
- R2: In a write transfer, SDA is sampled on each SCL rise, most significant bit first. Each completed byte is acknowledged by holding SDA low during the ninth clock and is presented on `rx_data` with `rx_valid`.
- R3: While `rx_valid` is high and `rx_ready` is low, `rx_data` and `rx_valid` hold. A write byte that completes while the held byte is not being accepted in that cycle is not acknowledged and is dropped.
- R4: In a read transfer, a byte is fetched when it starts, with `tx_ready` high for that one cycle. The byte is `tx_data` if `tx_valid` is high and 8'hFF otherwise. It is shifted out most significant bit first, and SDA changes only while SCL is low.
- R5: A high SDA (no acknowledge) from the controller in the ninth clock of a read byte ends the read. SDA stays released and no further byte is fetched until a new Start.
- R6: A repeated Start, whether between bytes or in the middle of a byte, restarts address reception without a Stop.
- R7: A Stop releases SDA and returns the target to idle. Bytes clocked after it without a Start are ignored.
- R8: While a transfer is open, if filtered SCL stays at one level for `TMO_LIMIT` system clocks, `tmo_pulse` is high for exactly one cycle, SDA is released, and all traffic is ignored until the next Start.
- R9: No timeout is raised while no transfer is open, however long SCL holds its level.
- R10: If a Start is detected in the same cycle the watchdog would expire, the Start wins and no timeout is raised.
- R11: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks is ignored.
- R12: After reset, `sda_oe`, `rx_valid`, `tx_ready` and `tmo_pulse` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rx_data | output | 8 | Received write byte |
| rx_valid | output | 1 | `rx_data` holds an unaccepted byte |
| rx_ready | input | 1 | Consumer accepts the byte in this cycle |
| tx_data | input | 8 | Next byte to send in a read |
| tx_valid | input | 1 | `tx_data` is meaningful |
| tx_ready | output | 1 | A read byte is fetched in this cycle |
| tmo_pulse | output | 1 | One-cycle pulse when a SCL phase exceeds the limit |

## Verification
The watchdog expiring and a Start arriving can fall in the same cycle, and the Start has to win. The bench provokes this by holding SCL high after an address byte. It then drops SDA a swept number of cycles after the SCL rise, from two cycles before the limit to two cycles after it. Both lines pass through identical filters, so the raw cycle distance carries through unchanged. The bench expects no timeout pulse for distances up to the limit and exactly one pulse beyond it. In every case the following address byte must still be acknowledged, because a Start after a timeout is a valid fresh Start.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  // protocol phase of the target
  typedef enum logic [2:0] {
    ST_IDLE,    // no transfer, waiting for a Start
    ST_ADDR,    // shifting the address byte
    ST_WR,      // shifting a write data byte
    ST_HOLD8,   // eighth bit seen, waiting for the fall to drive ACK
    ST_ACK,     // driving ACK through the ninth clock
    ST_RD,      // shifting a read byte out
    ST_RD_ACK,  // sampling the controller's ACK/NACK
    ST_WAIT     // open transfer but ignored until Start/Stop
  } tgt_state_e;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2c_tgt_filt.sv
module i2c_tgt_filt #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  localparam int CW = $clog2(LEN + 1);

  logic [1:0]    sync;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      dout <= 1'b1;
      cnt  <= '0;
    end else begin
      sync <= {sync[0], din};
      if (sync[1] == dout) begin
        cnt <= '0;
      end else if (cnt == CW'(LEN - 1)) begin
        dout <= sync[1];
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R11
  filt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> dout == $past(sync[1]));

endmodule

// File: rtl/i2c_tgt_wdog.sv
module i2c_tgt_wdog #(
  parameter int LIMIT = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic restart,
  output logic tmo
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!active || restart) begin
      cnt <= '0;
    end else if (cnt != CW'(LIMIT - 1)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tmo = active && !restart && (cnt == CW'(LIMIT - 1));

  // R8
  tmo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !tmo);

endmodule

// File: rtl/i2c_tgt_wdt.sv
module i2c_tgt_wdt
  import i2c_tgt_pkg::*;
#(
  parameter logic [2:0] DEV_CODE  = 3'b110,
  parameter int         FILT_LEN  = 3,
  parameter int         TMO_LIMIT = 5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic [7:0]  rx_data,
  output logic        rx_valid,
  input  logic        rx_ready,
  input  logic [7:0]  tx_data,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic        tmo_pulse
);

  localparam logic [3:0] GROUP   = 4'b1010;
  localparam logic [6:0] MY_ADDR = {GROUP, DEV_CODE};
  localparam int         CNT_W   = $clog2(BYTE_W);

  // ---- line conditioning: index 0 = SCL, 1 = SDA
  logic [1:0] raw, filt;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_tgt_filt #(.LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw[g]),
      .dout (filt[g])
    );
  end

  logic scl_q, sda_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= filt[0];
      sda_q <= filt[1];
    end
  end

  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_rise = filt[0] & ~scl_q;
  assign scl_fall = ~filt[0] & scl_q;
  assign start_ev = filt[0] & scl_q & sda_q & ~filt[1];
  assign stop_ev  = filt[0] & scl_q & ~sda_q & filt[1];

  // ---- protocol state
  tgt_state_e       st;
  logic [CNT_W-1:0] bitcnt;
  logic [6:0]       shreg;
  logic [6:0]       txsh;
  logic             ack_q, rd_q;
  logic             tmo;

  i2c_tgt_wdog #(.LIMIT(TMO_LIMIT)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (st != ST_IDLE),
    .restart(scl_rise | scl_fall | start_ev),
    .tmo    (tmo)
  );
  assign tmo_pulse = tmo;

  logic       slot_free;
  logic [7:0] load_byte;
  logic [7:0] in_byte;
  assign slot_free = ~rx_valid | rx_ready;
  assign load_byte = tx_valid ? tx_data : 8'hFF;
  assign in_byte   = {shreg, filt[1]};
  assign tx_ready  = scl_fall && ((st == ST_ACK && rd_q) || st == ST_RD_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      txsh     <= '0;
      ack_q    <= 1'b0;
      rd_q     <= 1'b0;
      sda_oe   <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;

      if (tmo) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_ev) begin
        st     <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              shreg  <= in_byte[6:0];
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == CNT_W'(BYTE_W - 1)) begin
                st <= ST_HOLD8;
                if (st == ST_ADDR) begin
                  ack_q <= (shreg == MY_ADDR);
                  rd_q  <= filt[1];
                end else begin
                  rd_q  <= 1'b0;
                  ack_q <= slot_free;
                  if (slot_free) begin
                    rx_data  <= in_byte;
                    rx_valid <= 1'b1;
                  end
                end
              end
            end
          end
          ST_HOLD8: begin
            if (scl_fall) begin
              if (ack_q) begin
                sda_oe <= 1'b1;
                st     <= ST_ACK;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rd_q) begin
                txsh   <= load_byte[6:0];
                sda_oe <= ~load_byte[7];
                st     <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_WR;
              end
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bitcnt == CNT_W'(BYTE_W - 1)) begin
                sda_oe <= 1'b0;
                st     <= ST_RD_ACK;
              end else begin
                txsh   <= {txsh[5:0], 1'b0};
                sda_oe <= ~txsh[6];
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise && filt[1]) begin
              st <= ST_WAIT;
            end else if (scl_fall) begin
              txsh   <= load_byte[6:0];
              sda_oe <= ~load_byte[7];
              bitcnt <= '0;
              st     <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && filt[0] && !tmo) |=> $stable(sda_oe));

  // R3
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R8
  tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> (st == ST_IDLE && !sda_oe));

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !tmo) |=> !sda_oe);

endmodule

// File: tb/i2c_tgt_wdt_test.sv
module i2c_tgt_wdt_test;

  localparam int LIM = 200;
  localparam int H   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;
  logic [7:0] rx_data, tx_data;
  logic rx_valid, rx_ready = 1'b1, tx_valid = 1'b0, tx_ready, tmo_pulse;

  i2c_tgt_wdt #(.TMO_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tmo_pulse(tmo_pulse)
  );

  int total = 0, bad = 0;
  int tmo_n = 0, rx_n = 0, tx_idx = 0, ld_n = 0;
  logic [7:0] rx_log [0:63];

  function automatic logic [7:0] pat(input int i);
    return 8'hA5 ^ 8'(i * 59);
  endfunction
  assign tx_data = pat(tx_idx);

  always @(posedge clk) begin
    if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;
    if (tx_ready) ld_n <= ld_n + 1;
  end

  always @(negedge clk) begin
    if (tmo_pulse) tmo_n++;
    if (rx_valid && rx_ready) begin
      rx_log[rx_n[5:0]] = rx_data;
      rx_n++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk);
    rx_ready <= v;
    @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(H);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b0; tick(H);
    m_scl = 1'b0;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(H);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b1; tick(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; tick(H);
      m_scl = 1'b1; tick(H);
      m_scl = 1'b0;
    end
  endtask

  task automatic ack_slot(output logic ack);
    m_sda = 1'b1; tick(H);
    m_scl = 1'b1; tick(H / 2);
    ack = ~sda_line; tick(H / 2);
    m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    ack_slot(ack);
  endtask

  // sends b with a 2-cycle SCL blip in the low phase of bit g
  // and a 2-cycle SDA blip in its high phase
  task automatic send_byte_glitch(input logic [7:0] b, input int g, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i];
      if (i == g) begin
        tick(3); m_scl = 1'b1; tick(2); m_scl = 1'b0; tick(H - 5);
        m_scl = 1'b1;
        tick(3); m_sda = ~b[i]; tick(2); m_sda = b[i]; tick(H - 5);
      end else begin
        tick(H); m_scl = 1'b1; tick(H);
      end
      m_scl = 1'b0;
    end
    ack_slot(ack);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b, output logic stable);
    logic s0, s1;
    stable = 1'b1;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      m_scl = 1'b1; tick(1);
      s0 = sda_line; tick(H - 2);
      s1 = sda_line; tick(1);
      b[i] = s1;
      if (s0 !== s1) stable = 1'b0;
      m_scl = 1'b0;
    end
    m_sda = ~give_ack; tick(H);
    m_scl = 1'b1; tick(H);
    m_scl = 1'b0;
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic ack, stab;
    logic [7:0] b;
    int t0, r0, l0, x0;

    tick(5);
    rst_n = 1'b1;
    tick(2);
    // R12 reset state
    chk("R12 sda_oe", sda_oe, 0);
    chk("R12 rx_valid", rx_valid, 0);
    chk("R12 tx_ready", tx_ready, 0);
    chk("R12 tmo_pulse", tmo_pulse, 0);

    // R1 full address sweep
    for (int a = 0; a < 256; a++) begin
      logic [7:0] av;
      av = 8'(a);
      bus_start;
      send_byte(av, ack);
      chk("R1 address ack", ack, av[7:1] == 7'h56);
      if (!av[0]) begin
        send_byte(8'h5A, ack);
        chk("R1 data after address", ack, av == 8'hAC);
      end
      bus_stop;
    end
    chk("R1 delivered count", rx_n, 1);
    chk("R1 delivered byte", rx_log[0], 8'h5A);

    // R2 multi-byte write
    r0 = rx_n;
    bus_start; send_byte(8'hAC, ack);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] v;
      v = 8'(k * 8'h69) ^ 8'h0F;
      send_byte(v, ack);
      chk("R2 data ack", ack, 1);
    end
    bus_stop;
    tick(3);
    chk("R2 count", rx_n - r0, 4);
    for (int k = 0; k < 4; k++)
      chk("R2 data value", rx_log[r0 + k], 8'(k * 8'h69) ^ 8'h0F);

    // R3 back-pressure
    set_ready(1'b0);
    r0 = rx_n;
    bus_start; send_byte(8'hAC, ack);
    send_byte(8'h11, ack); chk("R3 first byte ack", ack, 1);
    send_byte(8'h22, ack); chk("R3 overflow nack", ack, 0);
    bus_stop;
    chk("R3 held valid", rx_valid, 1);
    chk("R3 held data", rx_data, 8'h11);
    set_ready(1'b1);
    tick(4);
    chk("R3 drained count", rx_n - r0, 1);
    chk("R3 drained byte", rx_log[r0], 8'h11);

    // R4 read with data offered
    tx_valid = 1'b1;
    x0 = tx_idx; l0 = ld_n;
    bus_start; send_byte(8'hAD, ack); chk("R4 read address ack", ack, 1);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k < 2, b, stab);
      chk("R4 read byte", b, pat(x0 + k));
      chk("R4 SDA stable while SCL high", stab, 1);
    end
    chk("R4 fetch count", ld_n - l0, 3);
    // R5 after NACK: nothing driven, nothing fetched
    recv_byte(1'b0, b, stab);
    chk("R5 released after nack", b, 8'hFF);
    chk("R5 no fetch after nack", ld_n - l0, 3);
    bus_stop;

    // R4 no data offered -> all ones
    tx_valid = 1'b0;
    x0 = tx_idx; l0 = ld_n;
    bus_start; send_byte(8'hAD, ack);
    recv_byte(1'b0, b, stab);
    bus_stop;
    chk("R4 idle fill byte", b, 8'hFF);
    chk("R4 fetch strobe without data", ld_n - l0, 1);
    chk("R4 no consume without valid", tx_idx - x0, 0);

    // R6 repeated start after a byte and mid-byte
    r0 = rx_n;
    bus_start; send_byte(8'hAC, ack);
    send_byte(8'h77, ack);
    bus_start; send_byte(8'hAC, ack);
    chk("R6 restart after byte", ack, 1);
    send_bits(8'h00, 3);
    bus_start; send_byte(8'hAD, ack);
    chk("R6 restart mid byte", ack, 1);
    recv_byte(1'b0, b, stab);
    bus_stop;
    chk("R6 partial byte not delivered", rx_n - r0, 1);

    // R7 stop then traffic without start
    r0 = rx_n;
    bus_start; send_byte(8'hAC, ack); bus_stop;
    chk("R7 released after stop", sda_oe, 0);
    m_scl = 1'b0;
    send_byte(8'h33, ack);
    chk("R7 ignored after stop", ack, 0);
    bus_stop;
    chk("R7 nothing delivered", rx_n - r0, 0);

    // R8 SCL held high
    t0 = tmo_n; r0 = rx_n;
    bus_start; send_byte(8'hAC, ack);
    send_byte(8'h42, ack);
    m_sda = 1'b1; tick(H);
    m_scl = 1'b1; tick(LIM + 60);
    chk("R8 high-phase timeout", tmo_n - t0, 1);
    m_scl = 1'b0;
    send_byte(8'h99, ack);
    chk("R8 ignored after timeout", ack, 0);
    bus_start; send_byte(8'hAC, ack);
    chk("R8 fresh start accepted", ack, 1);
    bus_stop;
    chk("R8 delivered only pre-timeout byte", rx_n - r0, 1);

    // R8 SCL held low while ACK driven
    t0 = tmo_n;
    bus_start; send_bits(8'hAC, 8);
    tick(LIM + 60);
    chk("R8 low-phase timeout", tmo_n - t0, 1);
    chk("R8 SDA released on timeout", sda_oe, 0);
    bus_stop;

    // R9 no timeout outside a transfer
    t0 = tmo_n;
    tick(3 * LIM);
    m_scl = 1'b0; tick(3 * LIM); m_scl = 1'b1; tick(H);
    chk("R9 quiet when idle", tmo_n - t0, 0);

    // R10 start against expiry
    for (int d = LIM - 2; d <= LIM + 2; d++) begin
      t0 = tmo_n;
      bus_start; send_byte(8'hAC, ack);
      m_sda = 1'b1; tick(H);
      m_scl = 1'b1; tick(d);
      m_sda = 1'b0; tick(H);
      m_scl = 1'b0;
      send_byte(8'hAC, ack);
      chk("R10 address after race", ack, 1);
      bus_stop;
      chk("R10 timeout count", tmo_n - t0, (d > LIM) ? 1 : 0);
    end

    // R11 glitches filtered
    r0 = rx_n;
    bus_start; send_byte(8'hAC, ack);
    send_byte_glitch(8'h5A, 4, ack);
    chk("R11 ack through glitches", ack, 1);
    bus_stop;
    chk("R11 count", rx_n - r0, 1);
    chk("R11 byte", rx_log[r0], 8'h5A);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule